// File: doc/BRIEF.md
# Serial Bus-State Phase Tracker

This block sits on the device side of a three-wire serial link: a serial clock, a bus-state line and one data line. The host moves the link through four phases in a fixed cycle (command, handshake, data, acknowledge), and it marks each move by flipping the bus-state line. The line flips one bit period early, so one more bit of the old phase follows the flip. The tracker follows this cycle. It shifts data in, most significant bit first, on rising serial-clock edges. It delivers each completed byte with a one-cycle strobe and a flag for the final byte of the phase. A bus-state flip that comes before the phase can hold a full byte is reported as a protocol error, and the tracker returns to the command phase.

The device does not show readiness by a line level. When the surrounding logic asks for it, the block sends a fixed byte, 0xAA or 0x55, on the data line. Each bit is driven on a falling serial-clock edge, and the driver is released afterwards. The serial clock is sampled by the system clock. It must stay at each level for at least one system clock cycle, and the inputs are assumed to be already synchronous.

Top module: `bsp_phase_tracker`

## Requirements
- R1: `phase` shows the current phase, encoded command=0, handshake=1, data=2, acknowledge=3. The only change that is not an error moves it one step forward, one system cycle after the serial-clock rise that samples the phase's final bit.
- R2: A phase that ends while `phase` is acknowledge (3) is followed by command (0).
- R3: On each rising serial-clock edge, `sdi` is shifted in most significant bit first. After every eighth bit of a phase, `rx_byte` shows the byte and `rx_valid` is high for exactly one system cycle, one cycle after that edge. `rx_byte` keeps its value between strobes.
- R4: The bit sampled at the rise where a bus-state change is first seen, and exactly one bit after it, belong to the old phase. If that extra bit completes a byte, its strobe has `rx_last` high. Every other strobe has `rx_last` low.
- R5: If the extra bit does not complete a byte, the partial bits are discarded without a strobe, and the next phase starts with an empty byte.
- R6: A bus-state change seen at a rise is an error when no byte has yet been completed in the phase and fewer than six bits of the phase are held. Then `proto_err` pulses for one cycle, `phase` becomes command, the held bits and that bit are dropped, and no strobe follows.
- R7: A `ready_req` pulse loads 0xAA when `ready_sel`=0 or 0x55 when `ready_sel`=1. The next eight falling serial-clock edges drive its bits on `sdo`, most significant first, with `sdo_oe` high. The ninth falling edge releases the line (`sdo_oe`=0, `sdo`=0).
- R8: A `ready_req` that arrives while a pattern is loaded or being sent has no effect. The pattern in progress completes unchanged, and no second pattern follows.
- R9: While `rst_n` is low at a clock edge, the block goes to the command phase. It clears `rx_byte` and the received bits, holds the strobes low, releases the data driver, and takes the present bus-state level as its reference.
- R10: Without serial-clock edges, the level of `sdi` (for example, held high) produces no strobe and does not start or stop the ready pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk | input | 1 | Serial clock from the host |
| bus_state | input | 1 | Phase-marking line from the host |
| sdi | input | 1 | Serial data from the host |
| ready_req | input | 1 | Request to send the ready pattern |
| ready_sel | input | 1 | Pattern select: 0 gives 0xAA, 1 gives 0x55 |
| phase | output | 2 | Current phase (0 command, 1 handshake, 2 data, 3 acknowledge) |
| rx_byte | output | 8 | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe for a completed byte |
| rx_last | output | 1 | With rx_valid: the byte is the final one of its phase |
| proto_err | output | 1 | One-cycle pulse on an early bus-state change |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for sdo |

## Verification
A bit counter that is off by one shows up in two ways at the first byte boundary: `rx_byte` carries a rotated value and the strobe lands on the wrong rise. A stale bus-state reference makes `phase` step, or `proto_err` pulse, at the very next serial-clock rise. A wrong transmit count shows as an `sdo_oe` window that is too short or too long at the ninth falling edge. The bench model predicts every output for every system cycle, so each of these faults is reported in the cycle after the edge where it first appears.

// File: rtl/bsp_pkg.sv
`timescale 1ns/1ps
package bsp_pkg;
    typedef enum logic [1:0] {
        PH_CMD = 2'd0,
        PH_HSK = 2'd1,
        PH_DAT = 2'd2,
        PH_ACK = 2'd3
    } bsp_phase_e;
endpackage

// File: rtl/bsp_sclk_edge.sv
`timescale 1ns/1ps
module bsp_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_d, sclk_q;

    always_comb begin
        sclk_d = rst_n ? sclk : 1'b0;
    end

    always_ff @(posedge clk) begin
        sclk_q <= sclk_d;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/bsp_rx_phase.sv
`timescale 1ns/1ps
module bsp_rx_phase
    import bsp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              bus_state,
    input  logic              sdi,
    output bsp_phase_e        phase,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_last,
    output logic              proto_err
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] MIN_BITS = CNT_W'(BYTE_W - 2);

    typedef struct packed {
        bsp_phase_e        phase;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  bitcnt;
        logic              got_byte;
        logic              pend;
        logic              bs_ref;
        logic [BYTE_W-1:0] out_byte;
        logic              valid;
        logic              last;
        logic              err;
    } rx_state_t;

    rx_state_t d, q;
    logic [BYTE_W-1:0] sh_next;
    logic              byte_done;
    logic [1:0]        phase_inc;

    always_comb begin
        sh_next   = {q.shreg[BYTE_W-2:0], sdi};
        byte_done = (q.bitcnt == LAST_BIT);
        phase_inc = q.phase + 2'd1;
        d         = q;
        d.valid   = 1'b0;
        d.last    = 1'b0;
        d.err     = 1'b0;
        if (!rst_n) begin
            d.phase    = PH_CMD;
            d.shreg    = '0;
            d.bitcnt   = '0;
            d.got_byte = 1'b0;
            d.pend     = 1'b0;
            d.bs_ref   = bus_state;
            d.out_byte = '0;
        end else if (rise) begin
            if (q.pend) begin
                if (byte_done) begin
                    d.out_byte = sh_next;
                    d.valid    = 1'b1;
                    d.last     = 1'b1;
                end
                d.phase    = bsp_phase_e'(phase_inc);
                d.shreg    = '0;
                d.bitcnt   = '0;
                d.got_byte = 1'b0;
                d.pend     = 1'b0;
                d.bs_ref   = bus_state;
            end else if ((bus_state != q.bs_ref) && !q.got_byte && (q.bitcnt < MIN_BITS)) begin
                d.bs_ref   = bus_state;
                d.err      = 1'b1;
                d.phase    = PH_CMD;
                d.shreg    = '0;
                d.bitcnt   = '0;
                d.got_byte = 1'b0;
            end else begin
                if (bus_state != q.bs_ref) begin
                    d.bs_ref = bus_state;
                    d.pend   = 1'b1;
                end
                d.shreg = sh_next;
                if (byte_done) begin
                    d.out_byte = sh_next;
                    d.valid    = 1'b1;
                    d.bitcnt   = '0;
                    d.got_byte = 1'b1;
                end else begin
                    d.bitcnt = q.bitcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign phase     = q.phase;
    assign rx_byte   = q.out_byte;
    assign rx_valid  = q.valid;
    assign rx_last   = q.last;
    assign proto_err = q.err;

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase != $past(phase)) && !proto_err) |-> (phase == 2'($past(phase) + 2'd1))) // R1
        else $error("phase skipped a step");
    AST_ERR_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (phase == PH_CMD)) // R6
        else $error("error without return to command");
    AST_ERR_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> !rx_valid) // R6
        else $error("error together with a strobe");
    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_last |-> rx_valid) // R4
        else $error("last flag without strobe");
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid) // R3
        else $error("strobe longer than one cycle");
    AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rise)) // R3
        else $error("strobe without serial clock rise");
endmodule

// File: rtl/bsp_ready_tx.sv
`timescale 1ns/1ps
module bsp_ready_tx #(
    parameter int                BYTE_W = 8,
    parameter logic [BYTE_W-1:0] PAT_A  = 8'hAA,
    parameter logic [BYTE_W-1:0] PAT_B  = 8'h55
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic ready_req,
    input  logic ready_sel,
    output logic sdo,
    output logic sdo_oe
);
    localparam int TCW = $clog2(BYTE_W + 1);
    localparam logic [TCW-1:0] ALL_SENT = TCW'(BYTE_W);

    typedef struct packed {
        logic              act;
        logic [TCW-1:0]    cnt;
        logic [BYTE_W-1:0] sh;
        logic              oe;
        logic              sdo;
    } tx_state_t;

    tx_state_t d, q;

    always_comb begin
        d = q;
        if (!rst_n) begin
            d = '0;
        end else if (q.act) begin
            if (fall) begin
                if (q.cnt != ALL_SENT) begin
                    d.sdo = q.sh[BYTE_W-1];
                    d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                    d.oe  = 1'b1;
                    d.cnt = q.cnt + 1'b1;
                end else begin
                    d.sdo = 1'b0;
                    d.oe  = 1'b0;
                    d.act = 1'b0;
                    d.cnt = '0;
                end
            end
        end else if (ready_req) begin
            d.act = 1'b1;
            d.cnt = '0;
            d.sh  = ready_sel ? PAT_B : PAT_A;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign sdo    = q.sdo;
    assign sdo_oe = q.oe;

    AST_OE_RISES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(fall)) // R7
        else $error("driver enabled off a falling edge");
    AST_OE_DROPS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo_oe) |-> $past(fall)) // R7
        else $error("driver released off a falling edge");
    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && !$past(fall)) |-> $stable(sdo)) // R7
        else $error("data changed between falling edges");
    AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo) // R7
        else $error("released line not low");
endmodule

// File: rtl/bsp_phase_tracker.sv
`timescale 1ns/1ps
module bsp_phase_tracker
    import bsp_pkg::*;
#(
    parameter int                BYTE_W = 8,
    parameter logic [BYTE_W-1:0] PAT_A  = 8'hAA,
    parameter logic [BYTE_W-1:0] PAT_B  = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              bus_state,
    input  logic              sdi,
    input  logic              ready_req,
    input  logic              ready_sel,
    output logic [1:0]        phase,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_last,
    output logic              proto_err,
    output logic              sdo,
    output logic              sdo_oe
);
    logic       rise, fall;
    bsp_phase_e phase_e;

    bsp_sclk_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .rise  (rise),
        .fall  (fall)
    );

    bsp_rx_phase #(.BYTE_W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .bus_state (bus_state),
        .sdi       (sdi),
        .phase     (phase_e),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .rx_last   (rx_last),
        .proto_err (proto_err)
    );

    bsp_ready_tx #(.BYTE_W(BYTE_W), .PAT_A(PAT_A), .PAT_B(PAT_B)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall      (fall),
        .ready_req (ready_req),
        .ready_sel (ready_sel),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    assign phase = phase_e;

    AST_RESET_STATE: assert property (@(posedge clk)
        !$past(rst_n) |-> ((phase == 2'd0) && !sdo_oe && !rx_valid && !proto_err)) // R9
        else $error("reset state wrong");
endmodule

// File: tb/tb_bsp_phase_tracker.sv
`timescale 1ns/1ps
module tb_bsp_phase_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       bus_state = 1'b0;
    logic       sdi = 1'b0;
    logic       ready_req = 1'b0;
    logic       ready_sel = 1'b0;
    logic [1:0] phase;
    logic [7:0] rx_byte;
    logic       rx_valid, rx_last, proto_err, sdo, sdo_oe;

    int errors = 0;
    int checks = 0;
    bit chk_en = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    bsp_phase_tracker dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .bus_state(bus_state), .sdi(sdi),
        .ready_req(ready_req), .ready_sel(ready_sel), .phase(phase), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .rx_last(rx_last), .proto_err(proto_err), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, evaluated on every rising clock edge
    int m_sclk, m_phase, m_bits, m_got, m_pend, m_bsref, m_sh;
    int e_phase, e_byte, e_valid, e_last, e_err, e_sdo, e_oe, m_act;
    bit txq[$];

    always @(posedge clk) begin
        int rs, fl;
        rs = (sclk && !m_sclk); fl = (!sclk && m_sclk);
        e_valid = 0; e_last = 0; e_err = 0;
        if (!rst_n) begin
            m_sclk = 0; m_phase = 0; m_bits = 0; m_got = 0; m_pend = 0;
            m_bsref = bus_state; m_sh = 0; e_byte = 0; e_sdo = 0; e_oe = 0; m_act = 0;
            txq.delete();
        end else begin
            m_sclk = sclk;
            if (rs) begin
                if (m_pend) begin
                    m_sh = ((m_sh << 1) | sdi) & 255;
                    if (m_bits == 7) begin e_byte = m_sh; e_valid = 1; e_last = 1; end
                    m_phase = (m_phase + 1) % 4;
                    m_bits = 0; m_got = 0; m_pend = 0; m_sh = 0; m_bsref = bus_state;
                end else if (bus_state != m_bsref && m_got == 0 && m_bits < 6) begin
                    m_bsref = bus_state; e_err = 1; m_phase = 0; m_bits = 0; m_sh = 0;
                end else begin
                    if (bus_state != m_bsref) begin m_bsref = bus_state; m_pend = 1; end
                    m_sh = ((m_sh << 1) | sdi) & 255;
                    m_bits++;
                    if (m_bits == 8) begin e_byte = m_sh; e_valid = 1; m_bits = 0; m_got = 1; end
                end
            end
            if (m_act) begin
                if (fl) begin
                    if (txq.size() > 0) begin e_sdo = txq.pop_front(); e_oe = 1; end
                    else begin e_sdo = 0; e_oe = 0; m_act = 0; end
                end
            end else if (ready_req) begin
                logic [7:0] p;
                p = ready_sel ? 8'h55 : 8'hAA;
                m_act = 1;
                for (int i = 7; i >= 0; i--) txq.push_back(p[i]);
            end
        end
        e_phase = m_phase;
        chk_en = 1;
    end

    // Every-cycle comparison, away from the active edge
    int nvalid = 0, nerr = 0;
    logic [7:0] last_byte;
    logic       last_flag;
    always @(negedge clk) begin
        if (chk_en && !done) begin
            check(phase == 2'(e_phase), "R1 phase", phase, e_phase);
            check(rx_byte == 8'(e_byte), "R3 rx_byte", rx_byte, e_byte);
            check(rx_valid == 1'(e_valid), "R3 rx_valid", rx_valid, e_valid);
            check(rx_last == 1'(e_last), "R4 rx_last", rx_last, e_last);
            check(proto_err == 1'(e_err), "R6 proto_err", proto_err, e_err);
            check(sdo == 1'(e_sdo), "R7 sdo", sdo, e_sdo);
            check(sdo_oe == 1'(e_oe), "R7 sdo_oe", sdo_oe, e_oe);
            if (rx_valid) begin nvalid++; last_byte = rx_byte; last_flag = rx_last; end
            if (proto_err) nerr++;
        end
    end

    int cur_bs = 0;
    logic [7:0] txcap;
    int txn;

    task automatic clk_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input bit d, input bit b);
        sdi = d; bus_state = b; sclk = 1'b0;
        clk_n(2);
        if (sdo_oe) begin txcap = {txcap[6:0], sdo}; txn++; end
        sclk = 1'b1;
        clk_n(2);
    endtask

    task automatic send_phase(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = base + 8'(i);
            for (int k = 7; k >= 0; k--)
                sbit(v[k], (i == n - 1 && k <= 1) ? !cur_bs[0] : cur_bs[0]);
        end
        cur_bs = !cur_bs[0];
    endtask

    task automatic finish_run;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int v0, e0;
        clk_n(3);
        // R9: reset state
        check(phase == 2'd0 && !sdo_oe && !rx_valid && rx_byte == 8'h00, "R9 reset", phase, 0);
        rst_n = 1'b1;
        clk_n(2);

        // R10: idle high data line, no clock edges
        sdi = 1'b1; v0 = nvalid;
        ready_sel = 1'b0;
        clk_n(20);
        check(nvalid == v0 && !sdo_oe, "R10 idle", nvalid - v0, 0);

        // R1/R4/R3: full cycle through the four phases
        v0 = nvalid;
        send_phase(1, 8'hA1);
        check(phase == 2'd1, "R1 to handshake", phase, 1);
        check(last_byte == 8'hA1 && last_flag, "R4 final byte flagged", last_byte, 8'hA1);
        send_phase(2, 8'h10);
        check(phase == 2'd2, "R1 to data", phase, 2);
        check(last_byte == 8'h11, "R3 msb first", last_byte, 8'h11);
        send_phase(3, 8'h7E);
        check(phase == 2'd3, "R1 to acknowledge", phase, 3);
        send_phase(1, 8'h3C);
        check(phase == 2'd0, "R2 wrap to command", phase, 0);
        check(nvalid - v0 == 7, "R3 byte count", nvalid - v0, 7);

        // R5: extra bit leaves a partial byte
        v0 = nvalid;
        for (int i = 0; i < 10; i++) sbit(1'(i % 3 == 0), (i >= 8) ? !cur_bs[0] : cur_bs[0]);
        cur_bs = !cur_bs[0];
        check(phase == 2'd1, "R5 phase advanced", phase, 1);
        check(nvalid - v0 == 1 && !last_flag, "R5 partial dropped", nvalid - v0, 1);

        // R6: early bus-state change
        e0 = nerr; v0 = nvalid;
        sbit(1, cur_bs[0]); sbit(0, cur_bs[0]); sbit(1, cur_bs[0]);
        sbit(1, !cur_bs[0]);
        cur_bs = !cur_bs[0];
        clk_n(1);
        check(nerr - e0 == 1 && phase == 2'd0, "R6 error to command", nerr - e0, 1);
        check(nvalid == v0, "R6 no strobe", nvalid - v0, 0);
        send_phase(1, 8'h5A);
        check(phase == 2'd1 && last_byte == 8'h5A, "R6 clean restart", last_byte, 8'h5A);

        // R7/R8: ready pattern 0xAA, second request while busy
        ready_sel = 1'b0; ready_req = 1'b1; clk_n(1); ready_req = 1'b0;
        txcap = 8'h00; txn = 0;
        for (int i = 0; i < 4; i++) sbit(1'(i), cur_bs[0]);
        ready_sel = 1'b1; ready_req = 1'b1; clk_n(1); ready_req = 1'b0;
        for (int i = 0; i < 8; i++) sbit(1'(i), cur_bs[0]);
        check(txcap == 8'hAA && txn == 8, "R7 pattern AA", txcap, 8'hAA);
        check(!sdo_oe, "R8 no second pattern", sdo_oe, 0);

        // R7: pattern 0x55
        ready_sel = 1'b1; ready_req = 1'b1; clk_n(1); ready_req = 1'b0;
        txcap = 8'h00; txn = 0;
        for (int i = 0; i < 10; i++) sbit(1'(i % 2), cur_bs[0]);
        check(txcap == 8'h55 && txn == 8 && !sdo_oe, "R7 pattern 55", txcap, 8'h55);

        // R9: reset in mid-phase and mid-pattern
        ready_req = 1'b1; clk_n(1); ready_req = 1'b0;
        for (int i = 0; i < 5; i++) sbit(1, cur_bs[0]);
        rst_n = 1'b0; sclk = 1'b0; clk_n(2);
        check(phase == 2'd0 && !sdo_oe && !sdo && rx_byte == 8'h00, "R9 mid reset", phase, 0);
        rst_n = 1'b1; clk_n(2);
        send_phase(1, 8'hC3);
        check(phase == 2'd1 && last_byte == 8'hC3, "R9 restart after reset", last_byte, 8'hC3);
        clk_n(4);
        finish_run();
    end
endmodule